// File: doc/BRIEF.md
# MDIO Management Frame and Polling Engine

This block is the management-port controller that sits between a register interface and the two-wire serial management bus of one or two Ethernet transceivers. Software places a complete 32-bit management word in the frame register. The engine then sends 32 idle ones, followed by that word MSB first, on the data pin, while it generates the management clock from the system clock. On a read it releases the data pin from the first turnaround bit onward and shifts the sixteen returned bits back into the low half of the frame register. Software learns that the transaction has finished from bit 16 of the frame register.

In polling mode the engine reads one configured transceiver register again and again, without help from software, with a short gap between reads. It keeps the most recent value. Each bit that differs between successive reads is marked as changed, and an interrupt rises when a changed bit is not masked. A bit-bang mode bypasses the sequencer: three one-bit registers then drive the clock, the data and the output enable directly.

Top module: `mdio_engine`

## Requirements
- R1: After reset, the frame, configuration and basic/status registers read 0, the mask register reads 0x0000FFFF, irq is 0, mdc is 0, mdioOe is 0 and mdioOut is 1.
- R2: The register addresses are: 0 frame, 1 configuration, 2 interrupt mask, 3 basic/status, 4 bit-bang clock, 5 bit-bang data, 6 bit-bang output enable. The configuration fields are: bit 0 line select, bit 1 poll enable, bit 2 bit-bang enable, bits 7:3 poll register, bits 14:10 poll PHY. Configuration bits 9:8 read back as 0.
- R3: A frame write accepted while idle sends 32 ones and then the 32 frame bits MSB first on mdioOut. mdc is a divided clock with a period of 2*DIV_HALF system clocks. mdioOut changes only on falling mdc, and is held low-clock when idle.
- R4: While a transaction is in flight, frame bit 16 reads 0. It reads 1 from exactly 128*DIV_HALF clocks after the edge that accepts the write.
- R5: A frame with opcode bits 29:28 = 10 is a read. mdioOe stays asserted through frame bit 13 and is released from frame bit 14 to the end. Input bits sampled on rising mdc during frame bits 16..31 land MSB first in frame bits 15:0.
- R6: A frame write made while a transaction is in flight is ignored: the register keeps its value and the wire carries the original frame.
- R7: Line select chooses which of the two mdioIn lines is sampled and which mdioOe bit is used. The other mdioOe bit stays 0.
- R8: With poll enable set and bit-bang clear, the engine repeatedly sends read frames that carry start 01, opcode 10 and the configured PHY and register, with POLL_GAP idle clocks between them.
- R9: Basic/status bits 31:16 hold the last polled value. Bits 15:0 accumulate every bit that differed from the previous poll. The first poll after a configuration write marks nothing.
- R10: irq is 1 exactly when some changed bit has a 0 in the mask register (a mask bit of 1 masks).
- R11: A read strobe (regRdEn) at address 3 returns the current value and then clears the changed bits, so irq falls on the next clock.
- R12: With bit-bang enable set, mdc, mdioOut and the selected mdioOe bit follow the three bit-bang registers, and frame writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears changed bits at address 3) |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data out |
| mdioOe | output | 2 | Per-line output enable |
| mdioIn | input | 2 | Per-line management data in |
| irq | output | 1 | Unmasked change interrupt |

## Verification
The assertions assume that software holds each register strobe for one clock, and that nothing but the engine's own completion sets changed bits. The clear-on-read property therefore excludes the cycle in which a poll finishes. The bench changes the transceiver model's value only between polls or in a way whose mixed result still marks the same bits. It makes every frame write during the low phase of the clock. It leaves polling on only in the windows where the interrupt and status checks run, so that the bit-bang and host-frame checks never race a poll.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_POS     = 14;   // first turnaround bit inside the frame
  localparam int DATA_POS   = 16;   // first data bit inside the frame

  localparam logic [2:0] ADDR_FRAME  = 3'd0;
  localparam logic [2:0] ADDR_CFG    = 3'd1;
  localparam logic [2:0] ADDR_MASK   = 3'd2;
  localparam logic [2:0] ADDR_STATUS = 3'd3;
  localparam logic [2:0] ADDR_BBCLK  = 3'd4;
  localparam logic [2:0] ADDR_BBDATA = 3'd5;
  localparam logic [2:0] ADDR_BBOE   = 3'd6;

  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic launch;      // a transaction starts this edge
    logic launchPoll;  // the starting transaction is a poll
    logic sampleNow;   // rising mdc this edge
    logic shiftNow;    // falling mdc, more bits follow
    logic doneNow;     // falling mdc after the last bit
    logic busy;
    logic kindPoll;
    logic pastTa;      // bit index at or beyond turnaround
    logic inData;      // bit index inside the data field
  } strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_HALF = 2,
  parameter int POLL_GAP = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameWrReq,
  input  logic    pollEn,
  input  logic    bbEn,
  output strobe_t strb,
  output logic    mdcEng
);
  localparam int TOTAL    = PRE_BITS + FRAME_BITS;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam int DIV_W    = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int GAP_W    = $clog2(POLL_GAP + 1);
  localparam int TA_IDX   = PRE_BITS + TA_POS;
  localparam int DATA_IDX = PRE_BITS + DATA_POS;

  logic             busy, kindPoll, mdcQ;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [GAP_W-1:0] gapCnt;
  logic             tick, lastBit, launchHost, launchPoll;

  always_comb begin
    tick       = busy && (divCnt == DIV_W'(DIV_HALF - 1));
    lastBit    = (bitIdx == IDX_W'(TOTAL - 1));
    launchHost = frameWrReq && !busy && !bbEn;
    launchPoll = !busy && pollEn && !bbEn && !launchHost && (gapCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      kindPoll <= 1'b0;
      mdcQ     <= 1'b0;
      divCnt   <= '0;
      bitIdx   <= '0;
      gapCnt   <= '0;
    end else if (launchHost || launchPoll) begin
      busy     <= 1'b1;
      kindPoll <= launchPoll;
      mdcQ     <= 1'b0;
      divCnt   <= '0;
      bitIdx   <= '0;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        mdcQ <= ~mdcQ;
        if (mdcQ) begin
          if (lastBit) begin
            busy   <= 1'b0;
            gapCnt <= GAP_W'(POLL_GAP);
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_comb begin
    strb.launch     = launchHost || launchPoll;
    strb.launchPoll = launchPoll;
    strb.sampleNow  = tick && !mdcQ;
    strb.shiftNow   = tick && mdcQ && !lastBit;
    strb.doneNow    = tick && mdcQ && lastBit;
    strb.busy       = busy;
    strb.kindPoll   = kindPoll;
    strb.pastTa     = (bitIdx >= IDX_W'(TA_IDX));
    strb.inData     = (bitIdx >= IDX_W'(DATA_IDX));
  end

  assign mdcEng = mdcQ;
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 mdcEng,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [2:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 cfgPe,
  output logic                 cfgBb,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic [NUM_LINES-1:0] mdioOe,
  input  logic [NUM_LINES-1:0] mdioIn,
  output logic                 irq
);
  localparam int TOTAL = PRE_BITS + FRAME_BITS;
  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [31:0]          frameReg;
  logic [SEL_W-1:0]     cfgSel;
  logic [4:0]           cfgPollReg, cfgPollPhy;
  logic [DATA_BITS-1:0] maskReg, basicReg, changedReg, rxShift, changedNext;
  logic                 pollValid, bbClk, bbData, bbOe, curRead;
  logic [TOTAL-1:0]     txShift;
  logic [31:0]          launchWord;
  logic                 wrCfg, statusClear, mdioInSel, engOe, oeSel;

  always_comb begin
    wrCfg       = regWrEn && (regAddr == ADDR_CFG);
    statusClear = regRdEn && (regAddr == ADDR_STATUS);
    mdioInSel   = mdioIn[cfgSel];
    if (strb.launchPoll)
      launchWord = {2'b01, OP_READ, cfgPollPhy, cfgPollReg, 2'b10, {DATA_BITS{1'b0}}};
    else
      launchWord = regWrData & ~32'h0001_0000;
    changedNext = statusClear ? '0 : changedReg;
    if (strb.doneNow && strb.kindPoll && pollValid)
      changedNext = changedNext | (basicReg ^ rxShift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg   <= '0;
      cfgSel     <= '0;
      cfgPe      <= 1'b0;
      cfgBb      <= 1'b0;
      cfgPollReg <= '0;
      cfgPollPhy <= '0;
      maskReg    <= '1;
      basicReg   <= '0;
      changedReg <= '0;
      pollValid  <= 1'b0;
      bbClk      <= 1'b0;
      bbData     <= 1'b0;
      bbOe       <= 1'b0;
      txShift    <= '1;
      rxShift    <= '0;
      curRead    <= 1'b0;
    end else begin
      changedReg <= changedNext;
      if (strb.launch) begin
        txShift <= {{PRE_BITS{1'b1}}, launchWord};
        curRead <= (launchWord[29:28] == OP_READ);
        if (!strb.launchPoll) frameReg <= launchWord;
      end else if (strb.shiftNow) begin
        txShift <= {txShift[TOTAL-2:0], 1'b1};
      end
      if (strb.sampleNow && strb.inData)
        rxShift <= {rxShift[DATA_BITS-2:0], mdioInSel};
      if (strb.doneNow) begin
        if (strb.kindPoll) begin
          basicReg  <= rxShift;
          pollValid <= 1'b1;
        end else begin
          frameReg[DATA_POS] <= 1'b1;
          if (curRead) frameReg[DATA_BITS-1:0] <= rxShift;
        end
      end
      if (regWrEn) begin
        case (regAddr)
          ADDR_CFG: begin
            cfgSel     <= SEL_W'(regWrData[0]);
            cfgPe      <= regWrData[1];
            cfgBb      <= regWrData[2];
            cfgPollReg <= regWrData[7:3];
            cfgPollPhy <= regWrData[14:10];
          end
          ADDR_MASK:   maskReg <= regWrData[DATA_BITS-1:0];
          ADDR_BBCLK:  bbClk   <= regWrData[0];
          ADDR_BBDATA: bbData  <= regWrData[0];
          ADDR_BBOE:   bbOe    <= regWrData[0];
          default: ;
        endcase
      end
      if (wrCfg) pollValid <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_FRAME:  regRdData = frameReg;
      ADDR_CFG:    regRdData = {17'b0, cfgPollPhy, 2'b00, cfgPollReg, cfgBb, cfgPe, 1'(cfgSel)};
      ADDR_MASK:   regRdData = {16'b0, maskReg};
      ADDR_STATUS: regRdData = {basicReg, changedReg};
      ADDR_BBCLK:  regRdData = {31'b0, bbClk};
      ADDR_BBDATA: regRdData = {31'b0, bbData};
      ADDR_BBOE:   regRdData = {31'b0, bbOe};
      default:     regRdData = '0;
    endcase
  end

  always_comb begin
    engOe   = strb.busy && !(curRead && strb.pastTa);
    oeSel   = cfgBb ? bbOe : engOe;
    mdc     = cfgBb ? bbClk : mdcEng;
    mdioOut = cfgBb ? bbData : (strb.busy ? txShift[TOTAL-1] : 1'b1);
    irq     = |(changedReg & ~maskReg);
  end

  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    assign mdioOe[ln] = oeSel && (cfgSel == SEL_W'(ln));
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_HALF = 2,
  parameter int POLL_GAP = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic [1:0]  mdioOe,
  input  logic [1:0]  mdioIn,
  output logic        irq
);
  strobe_t strb;
  logic    mdcEng, cfgPe, cfgBb, frameWrReq;

  assign frameWrReq = regWrEn && (regAddr == ADDR_FRAME);

  mdio_ctrl #(.PRE_BITS(PRE_BITS), .DIV_HALF(DIV_HALF), .POLL_GAP(POLL_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameWrReq(frameWrReq), .pollEn(cfgPe), .bbEn(cfgBb),
    .strb(strb), .mdcEng(mdcEng)
  );

  mdio_datapath #(.PRE_BITS(PRE_BITS), .NUM_LINES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mdcEng(mdcEng),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cfgPe(cfgPe), .cfgBb(cfgBb), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .irq(irq)
  );
endmodule

// File: rtl/mdio_engine_chk.sv
module mdio_engine_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regRdEn,
  input logic [2:0]  regAddr,
  input logic [14:0] frameHi,
  input logic        irq,
  input logic        mdc,
  input logic [1:0]  mdioOe,
  input logic        cfgBb,
  input strobe_t     strb
);
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && regAddr == ADDR_STATUS && !strb.doneNow |=> !irq); // R11

  AST_ONE_LINE_OE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(mdioOe) <= 1); // R7

  AST_BB_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    cfgBb |=> !$rose(strb.busy)); // R12

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy && !cfgBb |-> !mdc); // R3

  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy && regAddr == ADDR_FRAME |=> regAddr != ADDR_FRAME || frameHi == $past(frameHi)); // R6

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.launch, strb.sampleNow, strb.shiftNow, strb.doneNow})); // R3

  AST_LAUNCH_POLL_KIND: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch && strb.launchPoll |=> strb.kindPoll && !strb.pastTa && !strb.inData); // R8
endmodule

bind mdio_engine mdio_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .frameHi(regRdData[31:17]), .irq(irq), .mdc(mdc), .mdioOe(mdioOe),
  .cfgBb(cfgBb), .strb(strb)
);

// File: tb/mdio_engine_tb.sv
`timescale 1ns/1ps
module mdio_engine_tb;
  localparam int DIV_HALF = 2;
  localparam int POLL_GAP = 8;
  localparam int TXN      = 128 * DIV_HALF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, irq;
  logic [1:0]  mdioOe;
  logic [1:0]  mdioIn = 2'b11;

  int checks = 0, errors = 0;

  // transceiver model state
  int          riseCnt = 0;
  int          phyLine = 0;
  logic [15:0] phyVal = '0;
  logic [63:0] wireCap = '0;
  logic [31:0] lastFrame = '0;
  logic        oeChk = 1'b0;
  logic [1:0]  oeExpAddr = '0, oeExpData = '0;

  always #2.5 clk = ~clk;

  mdio_engine #(.PRE_BITS(32), .DIV_HALF(DIV_HALF), .POLL_GAP(POLL_GAP)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge mdioOe[0] or posedge mdioOe[1]) riseCnt = 0;

  always @(posedge mdc) begin
    wireCap = {wireCap[62:0], mdioOut};
    riseCnt++;
    if (oeChk && riseCnt == 40) check("R5/R7 oe before turnaround", {30'b0, mdioOe}, {30'b0, oeExpAddr});
    if (oeChk && riseCnt == 56) check("R5/R7 oe in data field", {30'b0, mdioOe}, {30'b0, oeExpData});
    if (riseCnt == 64) lastFrame = wireCap[31:0];
  end

  always @(negedge mdc) begin
    automatic int fidx = riseCnt - 32;
    automatic logic b = 1'b1;
    if (fidx == 15) b = 1'b0;
    else if (fidx >= 16 && fidx <= 31) b = phyVal[31 - fidx];
    mdioIn = 2'b11;
    mdioIn[phyLine] = b;
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regPeek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      regPeek(3'd0, v);
      if (v[16]) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, frameA, frameB;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 reset state
    regPeek(3'd0, v); check("R1 frame", v, 32'h0);
    regPeek(3'd1, v); check("R1 cfg", v, 32'h0);
    regPeek(3'd2, v); check("R1 mask", v, 32'h0000FFFF);
    regPeek(3'd3, v); check("R1 status", v, 32'h0);
    check("R1 pins", {27'b0, irq, mdc, mdioOe, mdioOut}, 32'h1);

    // R2 register map readback
    regWrite(3'd1, 32'hFFFF_FFF8);
    regPeek(3'd1, v); check("R2 cfg fields", v, 32'h0000_7CF8);
    regWrite(3'd1, 32'h0);
    regWrite(3'd2, 32'h0000_1234);
    regPeek(3'd2, v); check("R2 mask", v, 32'h0000_1234);
    regWrite(3'd2, 32'h0000_FFFF);

    // R3 R4 host write frame, cycle-exact completion
    frameA = {2'b01, 2'b01, 5'd3, 5'd17, 2'b10, 16'hBEEF};
    oeChk = 1'b1; oeExpAddr = 2'b01; oeExpData = 2'b01;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = frameA;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (TXN - 1) @(posedge clk);
    @(negedge clk);
    check("R4 busy bit16", {31'b0, regRdData[16]}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R4 done bit16", regRdData, frameA | 32'h0001_0000);
    check("R3 wire frame", lastFrame, frameA);
    check("R3 preamble", wireCap[63:32], 32'hFFFF_FFFF);

    // R5 read, line 0
    phyVal = 16'hA5C3; phyLine = 0;
    oeExpAddr = 2'b01; oeExpData = 2'b00;
    regWrite(3'd0, {2'b01, 2'b10, 5'd3, 5'd1, 2'b10, 16'h0});
    waitDone();
    regPeek(3'd0, v); check("R5 read data", v, {2'b01, 2'b10, 5'd3, 5'd1, 2'b11, 16'hA5C3});

    // R6 write during transaction ignored
    frameA = {2'b01, 2'b01, 5'd1, 5'd2, 2'b10, 16'h1111};
    frameB = {2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h2222};
    oeExpAddr = 2'b01; oeExpData = 2'b01;
    regWrite(3'd0, frameA);
    repeat (60) @(posedge clk);
    regWrite(3'd0, frameB);
    waitDone();
    regPeek(3'd0, v); check("R6 frame kept", v, frameA | 32'h0001_0000);
    check("R6 wire kept", lastFrame, frameA);

    // R7 line select 1
    regWrite(3'd1, 32'h1);
    phyVal = 16'h0F5A; phyLine = 1;
    oeExpAddr = 2'b10; oeExpData = 2'b00;
    regWrite(3'd0, {2'b01, 2'b10, 5'd4, 5'd6, 2'b10, 16'h0});
    waitDone();
    regPeek(3'd0, v); check("R7 line1 data", {16'b0, v[15:0]}, 32'h0000_0F5A);
    oeChk = 1'b0;

    // R8 R9 R10 R11 polling
    phyLine = 0; phyVal = 16'h1234;
    regWrite(3'd1, (32'd9 << 10) | (32'd5 << 3) | 32'h2);
    repeat (3 * (TXN + POLL_GAP + 4)) @(posedge clk);
    regPeek(3'd3, v); check("R9 basic first", v, 32'h1234_0000);
    check("R8 poll fields", {18'b0, lastFrame[31:18]}, {18'b0, 2'b01, 2'b10, 5'd9, 5'd5});
    check("R10 irq none", {31'b0, irq}, 32'h0);
    phyVal = 16'h1234 ^ 16'h0101;
    repeat (2 * (TXN + POLL_GAP + 4)) @(posedge clk);
    regPeek(3'd3, v); check("R9 changed", v, {16'h1335, 16'h0101});
    check("R10 masked irq", {31'b0, irq}, 32'h0);
    regWrite(3'd2, 32'h0000_FEFF);
    @(negedge clk);
    check("R10 unmasked irq", {31'b0, irq}, 32'h1);
    regAddr = 3'd3; regRdEn = 1'b1;
    #1 check("R11 read value", regRdData, {16'h1335, 16'h0101});
    @(negedge clk);
    regRdEn = 1'b0;
    check("R11 cleared", regRdData, {16'h1335, 16'h0000});
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // R12 bit-bang
    regWrite(3'd1, 32'h0);
    repeat (TXN + POLL_GAP + 8) @(posedge clk);
    regPeek(3'd0, frameA);
    regWrite(3'd1, 32'h4);
    regWrite(3'd4, 32'h1);
    regWrite(3'd5, 32'h0);
    regWrite(3'd6, 32'h1);
    @(negedge clk);
    check("R12 bb pins", {29'b0, mdc, mdioOut, mdioOe[0]}, 32'h5);
    regWrite(3'd1, 32'h5);
    @(negedge clk);
    check("R12 bb line1 oe", {30'b0, mdioOe}, 32'h2);
    regWrite(3'd0, {2'b01, 2'b01, 5'd2, 5'd2, 2'b10, 16'h5555});
    repeat (20) @(posedge clk);
    regPeek(3'd0, v); check("R12 frame ignored", v, frameA);
    check("R12 mdc follows", {31'b0, mdc}, 32'h1);
    regWrite(3'd1, 32'h0);
    @(negedge clk);
    check("R12 exit idle", {29'b0, mdc, mdioOe}, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule